// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block turns thirty-two external pins into interrupt requests. Every pin first crosses into the core clock through a two-flop synchronizer. A per-line detector then watches the synchronized level for the trigger condition that software has chosen for that line. A detected event sets the line's pending bit. The pending bit stays set until software writes a one to it. A mask bit for each line decides whether a pending line reaches an output.

Software programs the block through a simple 32-bit word-addressed register port. Writes take effect on the clock edge. A read returns data one cycle after the address is presented. Lines 0 to 15 each drive their own interrupt output. Lines 16 to 31 are combined into one shared output, and the handler reads the pending registers to find out which of them fired.

Top module: `extirq_ctrl`

## Requirements
- R1: Word addresses 0 to 3 hold the trigger configuration, 4 to 7 the mask bits and 8 to 11 the pending bits. Register k of each kind covers lines 8k to 8k+7. Line n's 4-bit trigger field sits at bits (n mod 8)*4+3 down to (n mod 8)*4. Mask and pending bits for line n sit at bit n mod 8, and bits 31:8 of those registers read as 0. Read data is valid on the cycle after the address.
- R2: Trigger code 0 selects level low, 1 level high, 2 falling edge, 3 rising edge and 4 both edges. Codes 5 to 15 never set the pending bit.
- R3: In edge modes the pending bit sets once for a synchronized 0-to-1 change (rising), a 1-to-0 change (falling), or either change (both). A change in the opposite direction does not set it.
- R4: In level modes the pending bit sets on every clock while the level is active, including the cycle right after software clears it.
- R5: Writing a pending register clears each bit whose write-data bit is 1. Bits written with 0 keep their value, and a pending bit falls only through such a write.
- R6: A mask bit of 1 blocks the line from its output but does not stop the pending bit from being captured. A mask bit of 0 passes a pending line to its output.
- R7: Line n below 16 drives irq_line_o[n]. irq_shared_o is the OR of the unmasked pending lines 16 to 31.
- R8: After reset, all configuration and pending bits are 0, all mask bits are 1 and all interrupt outputs are 0.
- R9: All outputs are registered. When a pin change arrives between clock edges on an unmasked line in an edge mode, the output rises on the fourth clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pin_i | input | 32 | Asynchronous external pin levels |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data for reg_addr_i |
| irq_line_o | output | 16 | Dedicated interrupt outputs for lines 0 to 15 |
| irq_shared_o | output | 1 | Combined interrupt output for lines 16 to 31 |

## Verification
The bench drives each trigger mode with both directions of pin transition, on lines in every register group. This would catch a field decoded at the wrong bit offset, or an edge detector with its polarity reversed. It clears a level-high line while the level is still active and expects the bit back at once; a design that gave the clear priority over a new event would read 0 there. It writes zeros to a pending register to catch a design that loads the register instead of clearing bits. It then clears one of two pending shared lines to catch an output that follows only one line rather than the OR of all of them. A cycle-exact latency probe catches a missing or extra synchronizer or output register.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int TRIG_W = 4;

  typedef enum logic [TRIG_W-1:0] {
    TRIG_LVL_LO = 4'd0,
    TRIG_LVL_HI = 4'd1,
    TRIG_FALL   = 4'd2,
    TRIG_RISE   = 4'd3,
    TRIG_BOTH   = 4'd4
  } trig_e;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/extirq_detect.sv
module extirq_detect
  import extirq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic [NUM_LINES-1:0]        lvl_i,
  input  logic [NUM_LINES*TRIG_W-1:0] cfg_i,
  output logic [NUM_LINES-1:0]        event_o
);
  logic [NUM_LINES-1:0] prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= '0;
    else       prev_q <= lvl_i;
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [TRIG_W-1:0] mode;
    logic              hit;
    assign mode = cfg_i[n*TRIG_W +: TRIG_W];
    always_comb begin
      case (mode)
        TRIG_LVL_LO: hit = ~lvl_i[n];
        TRIG_LVL_HI: hit = lvl_i[n];
        TRIG_FALL:   hit = prev_q[n] & ~lvl_i[n];
        TRIG_RISE:   hit = ~prev_q[n] & lvl_i[n];
        TRIG_BOTH:   hit = prev_q[n] ^ lvl_i[n];
        default:     hit = 1'b0;
      endcase
    end
    assign event_o[n] = hit;
  end
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int NUM_LINES     = 32,
  parameter int LINES_PER_REG = 8,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NUM_LINES-1:0]        event_i,
  output logic [NUM_LINES*TRIG_W-1:0] cfg_o,
  output logic [NUM_LINES-1:0]        mask_o,
  output logic [NUM_LINES-1:0]        pend_o,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int GROUPS   = NUM_LINES / LINES_PER_REG;
  localparam int CFG_BITS = LINES_PER_REG * TRIG_W;
  localparam int MASK_BASE = GROUPS;
  localparam int PEND_BASE = 2 * GROUPS;

  logic [NUM_LINES*TRIG_W-1:0] cfg_q;
  logic [NUM_LINES-1:0]        mask_q;
  logic [NUM_LINES-1:0]        pend_q;
  logic [NUM_LINES-1:0]        clr;
  logic [DATA_W-1:0]           rd_next;

  always_comb begin
    clr = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (we_i && addr_i == ADDR_W'(PEND_BASE + g))
        clr[g*LINES_PER_REG +: LINES_PER_REG] = wdata_i[LINES_PER_REG-1:0];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cfg_q  <= '0;
      mask_q <= '1;
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr) | event_i;
      if (we_i) begin
        for (int g = 0; g < GROUPS; g++) begin
          if (addr_i == ADDR_W'(g))
            cfg_q[g*CFG_BITS +: CFG_BITS] <= wdata_i[CFG_BITS-1:0];
          if (addr_i == ADDR_W'(MASK_BASE + g))
            mask_q[g*LINES_PER_REG +: LINES_PER_REG] <= wdata_i[LINES_PER_REG-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (addr_i == ADDR_W'(g))
        rd_next[CFG_BITS-1:0] = cfg_q[g*CFG_BITS +: CFG_BITS];
      if (addr_i == ADDR_W'(MASK_BASE + g))
        rd_next[LINES_PER_REG-1:0] = mask_q[g*LINES_PER_REG +: LINES_PER_REG];
      if (addr_i == ADDR_W'(PEND_BASE + g))
        rd_next[LINES_PER_REG-1:0] = pend_q[g*LINES_PER_REG +: LINES_PER_REG];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_o <= '0;
    else       rdata_o <= rd_next;
  end

  assign cfg_o  = cfg_q;
  assign mask_o = mask_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_LINES     = 32,
  parameter int LINES_PER_REG = 8,
  parameter int DIRECT_LINES  = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [NUM_LINES-1:0]    pin_i,
  input  logic                    reg_we_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output logic [DIRECT_LINES-1:0] irq_line_o,
  output logic                    irq_shared_o
);
  logic [NUM_LINES-1:0]        lvl_sync;
  logic [NUM_LINES-1:0]        line_event;
  logic [NUM_LINES*TRIG_W-1:0] cfg_q;
  logic [NUM_LINES-1:0]        mask_q;
  logic [NUM_LINES-1:0]        pend_q;
  logic [NUM_LINES-1:0]        live;

  extirq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(pin_i), .q_o(lvl_sync)
  );

  extirq_detect #(.NUM_LINES(NUM_LINES)) u_detect (
    .clk_i(clk_i), .rst_i(rst_i), .lvl_i(lvl_sync),
    .cfg_i(cfg_q), .event_o(line_event)
  );

  extirq_regs #(
    .NUM_LINES(NUM_LINES), .LINES_PER_REG(LINES_PER_REG),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .event_i(line_event), .cfg_o(cfg_q),
    .mask_o(mask_q), .pend_o(pend_q), .rdata_o(reg_rdata_o)
  );

  assign live = pend_q & ~mask_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_line_o   <= '0;
      irq_shared_o <= 1'b0;
    end else begin
      irq_line_o   <= live[DIRECT_LINES-1:0];
      irq_shared_o <= |live[NUM_LINES-1:DIRECT_LINES];
    end
  end
endmodule

// File: rtl/extirq_chk.sv
module extirq_chk
  import extirq_pkg::*;
#(
  parameter int NUM_LINES     = 32,
  parameter int LINES_PER_REG = 8,
  parameter int DIRECT_LINES  = 16,
  parameter int ADDR_W        = 4
) (
  input logic                        clk_i,
  input logic                        rst_i,
  input logic                        we_i,
  input logic [ADDR_W-1:0]           addr_i,
  input logic [LINES_PER_REG-1:0]    wdata_i,
  input logic [NUM_LINES*TRIG_W-1:0] cfg_q,
  input logic [NUM_LINES-1:0]        mask_q,
  input logic [NUM_LINES-1:0]        pend_q,
  input logic [DIRECT_LINES-1:0]     irq_line_o,
  input logic                        irq_shared_o
);
  localparam int GROUPS    = NUM_LINES / LINES_PER_REG;
  localparam int PEND_BASE = 2 * GROUPS;

  // R8
  reset_state_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (mask_q == '1 && irq_line_o == '0 && !irq_shared_o));

  // R7
  shared_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(mask_q[NUM_LINES-1:DIRECT_LINES] == '1) |-> !irq_shared_o);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    // R5
    w1c_only_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(pend_q[i]) |-> $past(we_i && addr_i == ADDR_W'(PEND_BASE + i / LINES_PER_REG)
                                 && wdata_i[i % LINES_PER_REG]));
    // R2
    bad_mode_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(pend_q[i]) |-> ($past(cfg_q[i*TRIG_W +: TRIG_W]) <= 4'd4));
  end

  for (genvar i = 0; i < DIRECT_LINES; i++) begin : g_direct
    // R6
    masked_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $past(mask_q[i]) |-> !irq_line_o[i]);
  end
endmodule

bind extirq_ctrl extirq_chk #(
  .NUM_LINES(NUM_LINES), .LINES_PER_REG(LINES_PER_REG),
  .DIRECT_LINES(DIRECT_LINES), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
  .wdata_i(reg_wdata_i[LINES_PER_REG-1:0]), .cfg_q(cfg_q), .mask_q(mask_q),
  .pend_q(pend_q), .irq_line_o(irq_line_o), .irq_shared_o(irq_shared_o)
);

// File: tb/extirq_ctrl_bench.sv
`timescale 1ns/1ps
module extirq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pins = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_line;
  logic        irq_shared;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  extirq_ctrl u_extirq_ctrl (
    .clk_i(clk), .rst_i(rst), .pin_i(pins), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_line_o(irq_line), .irq_shared_o(irq_shared)
  );

  // {line[4:0], mode[3:0], start level, end level}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {5'd3,  4'd3, 1'b0, 1'b1}, {5'd3,  4'd3, 1'b1, 1'b0},
    {5'd9,  4'd2, 1'b1, 1'b0}, {5'd9,  4'd2, 1'b0, 1'b1},
    {5'd12, 4'd4, 1'b0, 1'b1}, {5'd12, 4'd4, 1'b1, 1'b0},
    {5'd0,  4'd1, 1'b0, 1'b1}, {5'd0,  4'd1, 1'b0, 1'b0},
    {5'd15, 4'd0, 1'b1, 1'b1}, {5'd20, 4'd3, 1'b0, 1'b1},
    {5'd27, 4'd0, 1'b1, 1'b0}, {5'd31, 4'd6, 1'b0, 1'b1}
  };

  function automatic logic exp_pend(input int md, input logic s, input logic e);
    case (md)
      0: return !s || !e;
      1: return s || e;
      2: return s && !e;
      3: return !s && e;
      4: return s ^ e;
      default: return 1'b0;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic reg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic run_vec(input logic [10:0] v);
    int ln; int md; int grp; int bitp;
    logic s; logic e; logic ex; logic got;
    logic [31:0] rd;
    ln = int'(v[10:6]); md = int'(v[5:2]); s = v[1]; e = v[0];
    grp = ln / 8; bitp = ln % 8;
    pins[ln] = s;
    tick(5);
    reg_write(grp, 32'(md) << (bitp * 4));
    tick(3);
    reg_write(8 + grp, 32'hFF);
    reg_write(4 + grp, 32'hFF & ~(32'd1 << bitp));
    tick(2);
    pins[ln] = e;
    tick(6);
    reg_read(8 + grp, rd);
    ex = exp_pend(md, s, e);
    // R2 / R3 / R4: pending capture per trigger mode
    check(rd[bitp] == ex, (md <= 1) ? "R4" : ((md <= 4) ? "R3" : "R2"),
          32'(rd[bitp]), 32'(ex));
    got = (ln < 16) ? irq_line[ln] : irq_shared;
    // R7: routing to dedicated or shared output
    check(got == ex, "R7", 32'(got), 32'(ex));
    reg_write(4 + grp, 32'hFF);
    pins[ln] = 1'b0;
    tick(2);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    tick(4);
    rst = 1'b0;
    // R8: reset state
    check(irq_line == 16'h0 && !irq_shared, "R8", {15'd0, irq_shared, irq_line}, 32'h0);
    reg_read(0, rd);
    check(rd == 32'h0, "R8", rd, 32'h0);
    reg_read(4, rd);
    check(rd == 32'hFF, "R8", rd, 32'hFF);
    reg_read(7, rd);
    check(rd == 32'hFF, "R8", rd, 32'hFF);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R5 / R6: masked capture, write-zero ignored, write-one clears
    reg_write(0, 32'h0030_0000);
    tick(3);
    reg_write(8, 32'hFF);
    pins[5] = 1'b1;
    tick(6);
    reg_read(8, rd);
    check(rd[5] == 1'b1, "R6", 32'(rd[5]), 32'h1);
    check(irq_line[5] == 1'b0, "R6", 32'(irq_line[5]), 32'h0);
    reg_write(8, 32'h00);
    reg_read(8, rd);
    check(rd[5] == 1'b1, "R5", 32'(rd[5]), 32'h1);
    reg_write(8, 32'h20);
    tick(1);
    reg_read(8, rd);
    check(rd[5] == 1'b0, "R5", 32'(rd[5]), 32'h0);

    // R4: level high re-sets right after clear
    reg_write(1, 32'h1);
    pins[8] = 1'b1;
    tick(6);
    reg_write(9, 32'h01);
    reg_read(9, rd);
    check(rd[0] == 1'b1, "R4", 32'(rd[0]), 32'h1);
    pins[8] = 1'b0;

    // R7: shared output ORs lines 17 and 30
    reg_write(2, 32'h30);
    reg_write(3, 32'h0300_0000);
    tick(3);
    reg_write(10, 32'hFF);
    reg_write(11, 32'hFF);
    reg_write(6, 32'hFD);
    reg_write(7, 32'hBF);
    pins[17] = 1'b1; pins[30] = 1'b1;
    tick(6);
    check(irq_shared == 1'b1, "R7", 32'(irq_shared), 32'h1);
    reg_write(10, 32'h02);
    tick(2);
    check(irq_shared == 1'b1, "R7", 32'(irq_shared), 32'h1);
    reg_write(11, 32'h40);
    tick(2);
    check(irq_shared == 1'b0, "R7", 32'(irq_shared), 32'h0);

    // R1: field positions read back
    reg_read(2, rd);
    check(rd == 32'h30, "R1", rd, 32'h30);
    reg_read(7, rd);
    check(rd == 32'hBF, "R1", rd, 32'hBF);

    // R9: exact latency on line 2, rising edge
    reg_write(0, 32'h300);
    tick(3);
    reg_write(8, 32'hFF);
    reg_write(4, 32'hFB);
    tick(2);
    pins[2] = 1'b1;
    tick(3);
    check(irq_line[2] == 1'b0, "R9", 32'(irq_line[2]), 32'h0);
    tick(1);
    check(irq_line[2] == 1'b1, "R9", 32'(irq_line[2]), 32'h1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule